// File: doc/BRIEF.md
# Capture and PWM timer channel

This block is one 16-bit half of a general-purpose timer. It operates in one of three signal modes, and all three share a single counter. In edge-count mode it counts qualified transitions on an input pin and flags a match when the count reaches a programmed target. In edge-time mode a down counter runs freely, and each qualified transition latches the current count into a capture register. In PWM mode the same down counter sets the period, and a match value sets the duty cycle of an output whose polarity can be inverted.

An 8-bit prescale-match field sits above the 16-bit match value. In edge-count mode the two together form a 24-bit target, so the channel can count far more edges than 16 bits allow. The channel produces three one-cycle flags: capture event, capture match and timeout. A separate interrupt or DMA block consumes them. The configuration inputs are assumed to come from a register block elsewhere, and they are held steady while the channel is enabled.

Top module: `capt_pwm_chan`

## Requirements
- R1: After reset, count_o, pre_o and cap_o are 0, and pwm_o, evt_o, match_o and tout_o are low.
- R2: pin_i passes through two synchronizer flops and one history flop. A pin change first sampled at rising edge t takes effect at edge t+2: count_o still has its old value after edge t+1 and holds the new value after edge t+2.
- R3: The edge_sel_i code selects which transitions qualify: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none. A transition that does not qualify leaves the count unchanged.
- R4: With mode_i = 2'b00 (edge count), each qualified edge increments a 24-bit value whose upper 8 bits appear on pre_o and lower 16 bits on count_o. When the incremented value equals {pmatch_i, match_i}, match_o pulses for one cycle and the value returns to 0.
- R5: The prescale-match field extends the target. With pmatch_i = 1 and match_i = 0, no match occurs after 65535 edges (count_o = 16'hFFFF). The 65536th edge raises match_o and clears the count.
- R6: With mode_i = 2'b01 (edge time) or 2'b10 (PWM), the counter counts down by one each cycle from load_i. On the cycle after it reaches 0 it reloads load_i and pulses tout_o, which gives a timeout period of load_i+1 cycles. While tout_o is high, count_o equals load_i.
- R7: In edge-time mode a qualified edge pulses evt_o for one cycle. cap_o then holds the value count_o had in the cycle before evt_o rose. For a pin change driven while count_o is c, that value is c-2, taken modulo load_i+1.
- R8: In PWM mode with invert_i = 0, pwm_o is high in the cycle after the count was above match_i. Over any load_i+1 consecutive cycles it is high for load_i-match_i cycles, or for none when match_i >= load_i.
- R9: With invert_i = 1 the PWM output is active low, so it is high for match_i+1 cycles of each period. In every timeout cycle pwm_o is at its inactive level, which equals invert_i.
- R10: While enable_i is low, or mode_i = 2'b11, no flag pulses. The counter holds load_i (0 in edge-count mode, with pre_o = 0), and pwm_o sits at the level invert_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run the channel |
| mode_i | input | 2 | 00 edge count, 01 edge time, 10 PWM, 11 off |
| edge_sel_i | input | 2 | Qualifying transitions: 01 rise, 10 fall, 11 both, 00 none |
| invert_i | input | 1 | PWM output active low when set |
| load_i | input | 16 | Reload value of the down counter |
| match_i | input | 16 | Match value (count target or duty threshold) |
| pmatch_i | input | 8 | Upper 8 bits of the edge-count target |
| pin_i | input | 1 | Asynchronous capture input |
| pwm_o | output | 1 | PWM output |
| count_o | output | 16 | Lower 16 bits of the counter |
| pre_o | output | 8 | Upper 8 bits of the edge-count value |
| cap_o | output | 16 | Last captured count |
| evt_o | output | 1 | Capture-event pulse |
| match_o | output | 1 | Capture-match pulse |
| tout_o | output | 1 | Timeout pulse |

## Verification
The hardest condition to reach is the prescale-extended match. Getting there takes 65536 qualified edges, which is out of reach with ordinary slow pulses. The stimulus sets both-edge selection and toggles the pin on every clock, so each cycle yields one edge. It then checks that the count sits at 16'hFFFF with no match before the final edge brings the match. The second awkward case is a capture that lands across a reload. The stimulus waits until the count reads 1 before driving the pin, so the latched value must be the reload value and not a decremented one.

// File: rtl/cpw_pkg.sv
`timescale 1ns/1ps
package cpw_pkg;

  typedef enum logic [1:0] {
    MODE_ECOUNT = 2'b00,
    MODE_ETIME  = 2'b01,
    MODE_PWM    = 2'b10,
    MODE_OFF    = 2'b11
  } cpw_mode_e;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  // Bit 0 of the select admits rising transitions, bit 1 admits falling ones.
  function automatic logic edge_hit(input logic [1:0] sel, input logic rise,
                                    input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

endpackage

// File: rtl/cpw_sync_edge.sv
`timescale 1ns/1ps
module cpw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[0..STAGES-1] form the synchronizer; sh[STAGES] keeps the previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= pin_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[gi] <= 1'b0;
        else        sh[gi] <= sh[gi-1];
      end
    end
  endgenerate

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];

  generate
    if (STAGES == 2) begin : g_chk
      assert_rise_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, 2));
      assert_fall_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(pin_i, 2));
    end
  endgenerate

endmodule

// File: rtl/cpw_counter.sv
`timescale 1ns/1ps
module cpw_counter
  import cpw_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  cpw_mode_e     mode,
  input  logic [CW-1:0] load,
  input  logic [CW-1:0] match,
  input  logic [PW-1:0] pmatch,
  input  logic          hit,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] pre_o,
  output logic [CW-1:0] cap_o,
  output logic          evt_o,
  output logic          mat_o,
  output logic          tout_o
);
  localparam int XW = CW + PW;

  logic [XW-1:0] ext_q;
  logic [XW-1:0] ext_inc;
  logic [XW-1:0] ext_tgt;
  logic [XW-1:0] ext_idle;
  logic [CW-1:0] down_nx;
  logic          at_zero;
  logic          tgt_hit;

  function automatic logic [CW-1:0] f_down(input logic [CW-1:0] cur,
                                           input logic [CW-1:0] ld);
    return (cur == '0) ? ld : cur - 1'b1;
  endfunction

  assign ext_inc  = ext_q + 1'b1;
  assign ext_tgt  = {pmatch, match};
  assign tgt_hit  = (ext_inc == ext_tgt);
  assign at_zero  = (ext_q[CW-1:0] == '0);
  assign down_nx  = f_down(ext_q[CW-1:0], load);
  assign ext_idle = (mode == MODE_ECOUNT) ? '0 : {{PW{1'b0}}, load};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      cap_o  <= '0;
      evt_o  <= 1'b0;
      mat_o  <= 1'b0;
      tout_o <= 1'b0;
    end else begin
      evt_o  <= 1'b0;
      mat_o  <= 1'b0;
      tout_o <= 1'b0;
      if (!run) begin
        ext_q <= ext_idle;
      end else if (mode == MODE_ECOUNT) begin
        if (hit) begin
          if (tgt_hit) begin
            ext_q <= '0;
            mat_o <= 1'b1;
          end else begin
            ext_q <= ext_inc;
          end
        end
      end else begin
        ext_q  <= {{PW{1'b0}}, down_nx};
        tout_o <= at_zero;
        if (mode == MODE_ETIME && hit) begin
          cap_o <= ext_q[CW-1:0];
          evt_o <= 1'b1;
        end
      end
    end
  end

  assign cnt_o = ext_q[CW-1:0];
  assign pre_o = ext_q[XW-1:CW];

  assert_match_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mat_o |-> (ext_q == '0));
  assert_evt_from_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> ($past(hit) && $past(mode) == MODE_ETIME && $past(run)));

endmodule

// File: rtl/cpw_pwm_out.sv
`timescale 1ns/1ps
module cpw_pwm_out #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_pwm,
  input  logic          invert,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] match,
  output logic          pwm_o
);
  logic lvl_w;

  function automatic logic f_level(input logic [CW-1:0] c, input logic [CW-1:0] m,
                                   input logic inv);
    return (c > m) ^ inv;
  endfunction

  assign lvl_w = f_level(cnt, match, invert);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= run_pwm ? lvl_w : invert;
  end

endmodule

// File: rtl/capt_pwm_chan.sv
`timescale 1ns/1ps
module capt_pwm_chan
  import cpw_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    edge_sel_i,
  input  logic          invert_i,
  input  logic [CW-1:0] load_i,
  input  logic [CW-1:0] match_i,
  input  logic [PW-1:0] pmatch_i,
  input  logic          pin_i,
  output logic          pwm_o,
  output logic [CW-1:0] count_o,
  output logic [PW-1:0] pre_o,
  output logic [CW-1:0] cap_o,
  output logic          evt_o,
  output logic          match_o,
  output logic          tout_o
);
  cpw_mode_e mode_w;
  logic      run_w;
  logic      rise_w;
  logic      fall_w;
  logic      hit_w;
  logic      run_pwm_w;

  assign mode_w    = cpw_mode_e'(mode_i);
  assign run_w     = enable_i && (mode_w != MODE_OFF);
  assign run_pwm_w = run_w && (mode_w == MODE_PWM);
  assign hit_w     = edge_hit(edge_sel_i, rise_w, fall_w);

  cpw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  cpw_counter #(.CW(CW), .PW(PW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_w),
    .mode   (mode_w),
    .load   (load_i),
    .match  (match_i),
    .pmatch (pmatch_i),
    .hit    (hit_w),
    .cnt_o  (count_o),
    .pre_o  (pre_o),
    .cap_o  (cap_o),
    .evt_o  (evt_o),
    .mat_o  (match_o),
    .tout_o (tout_o)
  );

  cpw_pwm_out #(.CW(CW)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_pwm (run_pwm_w),
    .invert  (invert_i),
    .cnt     (count_o),
    .match   (match_i),
    .pwm_o   (pwm_o)
  );

  assert_none_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_w) && $past(mode_i) == MODE_ECOUNT && $past(edge_sel_i) == EDGE_NONE)
      |-> (count_o == $past(count_o)));
  assert_tout_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tout_o |-> (count_o == $past(load_i)));
  assert_tout_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_o && $past(mode_i) == MODE_PWM) |-> (pwm_o == $past(invert_i)));
  assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_w) |-> (!evt_o && !match_o && !tout_o));

endmodule

// File: tb/sim_capt_pwm_chan.sv
`timescale 1ns/1ps
module sim_capt_pwm_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  edge_sel_i = 2'b01;
  logic        invert_i = 1'b0;
  logic [15:0] load_i = 16'd0;
  logic [15:0] match_i = 16'd0;
  logic [7:0]  pmatch_i = 8'd0;
  logic        pin_i = 1'b0;
  logic        pwm_o;
  logic [15:0] count_o;
  logic [7:0]  pre_o;
  logic [15:0] cap_o;
  logic        evt_o;
  logic        match_o;
  logic        tout_o;

  capt_pwm_chan u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
    .edge_sel_i(edge_sel_i), .invert_i(invert_i), .load_i(load_i),
    .match_i(match_i), .pmatch_i(pmatch_i), .pin_i(pin_i), .pwm_o(pwm_o),
    .count_o(count_o), .pre_o(pre_o), .cap_o(cap_o), .evt_o(evt_o),
    .match_o(match_o), .tout_o(tout_o)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed { logic is_match; logic [15:0] val; } item_t;
  item_t exp_q[$];
  logic [23:0] m_ext = 24'd0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: every flag that carries a result is matched against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && (evt_o || match_o)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, evt_o ? "R7 unexpected capture" : "R4 unexpected match",
              int'(cap_o), -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.is_match)
          check(match_o && !evt_o, "R4 match event", int'(match_o), 1);
        else
          check(evt_o && (cap_o == it.val), "R7 captured value", int'(cap_o), int'(it.val));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: changes the pin on a falling clock edge and predicts edge-count results.
  task automatic set_pin(input logic v);
    bit q;
    @(negedge clk);
    q = (v && !pin_i && edge_sel_i[0]) || (!v && pin_i && edge_sel_i[1]);
    if (q && enable_i && mode_i == 2'b00) begin
      if (m_ext + 24'd1 == {pmatch_i, match_i}) begin
        m_ext = 24'd0;
        exp_q.push_back('{is_match: 1'b1, val: 16'd0});
      end else begin
        m_ext = m_ext + 24'd1;
      end
    end
    pin_i = v;
  endtask

  function automatic int exp_cap(input int c0, input int ld);
    return (c0 >= 2) ? c0 - 2 : c0 + ld + 1 - 2;
  endfunction

  task automatic cap_at();
    int c0;
    c0 = int'(count_o);
    exp_q.push_back('{is_match: 1'b0, val: 16'(exp_cap(c0, int'(load_i))) });
    pin_i = 1'b1;
  endtask

  task automatic wait_tout(output int at);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!tout_o && guard < 1000);
    at = cyc;
  endtask

  task automatic pwm_highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_o) h++; end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    int t1, t2, h;
    idle(3);
    check(count_o == 0 && pre_o == 0 && cap_o == 0, "R1 reset counters", int'(count_o), 0);
    check(!pwm_o && !evt_o && !match_o && !tout_o, "R1 reset outputs",
          int'({pwm_o, evt_o, match_o, tout_o}), 0);
    rst_n = 1'b1;

    // Edge count, rising edges, target 3
    @(negedge clk);
    mode_i = 2'b00; edge_sel_i = 2'b01; match_i = 16'd3; pmatch_i = 8'd0; enable_i = 1'b1;
    m_ext = 0;
    idle(2);
    set_pin(1'b1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(count_o == 0, "R2 count not yet updated", int'(count_o), 0);
    @(posedge clk); @(negedge clk);
    check(count_o == 1, "R2 count after third edge", int'(count_o), 1);
    set_pin(1'b0); idle(4);
    check(count_o == 1, "R3 falling ignored in rise mode", int'(count_o), 1);
    set_pin(1'b1); idle(4); set_pin(1'b0); idle(4);
    check(count_o == 2, "R4 second edge counted", int'(count_o), 2);
    set_pin(1'b1); idle(4); set_pin(1'b0); idle(4);
    check(count_o == 0 && exp_q.size() == 0, "R4 match clears count", int'(count_o), 0);

    // Falling only
    @(negedge clk); edge_sel_i = 2'b10; match_i = 16'd100;
    set_pin(1'b1); idle(4);
    check(count_o == 0, "R3 rising ignored in fall mode", int'(count_o), 0);
    set_pin(1'b0); idle(4);
    check(count_o == 1, "R3 falling counted", int'(count_o), 1);
    // Both edges
    @(negedge clk); edge_sel_i = 2'b11;
    set_pin(1'b1); idle(4); set_pin(1'b0); idle(4);
    check(count_o == 3, "R3 both edges counted", int'(count_o), 3);
    // None
    @(negedge clk); edge_sel_i = 2'b00;
    set_pin(1'b1); idle(4); set_pin(1'b0); idle(4);
    check(count_o == 3, "R3 no edge selected", int'(count_o), 3);

    // Disable clears, then prescale-extended target
    @(negedge clk); enable_i = 1'b0; idle(2);
    check(count_o == 0 && pre_o == 0, "R10 edge count held at zero", int'(count_o), 0);
    @(negedge clk); pmatch_i = 8'd1; match_i = 16'd0; edge_sel_i = 2'b11; enable_i = 1'b1;
    m_ext = 0;
    idle(2);
    for (int i = 0; i < 65535; i++) set_pin(~pin_i);
    idle(5);
    check(count_o == 16'hFFFF && pre_o == 0, "R5 count before extended match",
          int'(count_o), 65535);
    check(exp_q.size() == 0 && m_ext == 24'h00FFFF, "R5 no early match", int'(m_ext), 65535);
    set_pin(~pin_i); idle(5);
    check(count_o == 0 && pre_o == 0 && exp_q.size() == 0, "R5 extended match clears",
          int'(count_o), 0);

    // Edge time
    @(negedge clk); enable_i = 1'b0; mode_i = 2'b01; load_i = 16'd100; edge_sel_i = 2'b01;
    pmatch_i = 8'd0; match_i = 16'd0;
    idle(1); set_pin(1'b0); idle(4);
    check(count_o == 100 && !tout_o && !evt_o, "R10 disabled holds load", int'(count_o), 100);
    @(negedge clk); enable_i = 1'b1;
    wait_tout(t1);
    check(count_o == 100, "R6 reload value at timeout", int'(count_o), 100);
    wait_tout(t2);
    check(t2 - t1 == 101, "R6 timeout period", t2 - t1, 101);
    idle(7); cap_at(); idle(6); set_pin(1'b0); idle(4);
    idle(13); cap_at(); idle(6); set_pin(1'b0); idle(4);
    do @(negedge clk); while (count_o != 16'd1);
    cap_at(); idle(6); set_pin(1'b0); idle(4);
    do @(negedge clk); while (count_o != 16'd0);
    cap_at(); idle(6); set_pin(1'b0); idle(4);
    check(exp_q.size() == 0, "R7 all captures seen", exp_q.size(), 0);

    // PWM
    @(negedge clk); enable_i = 1'b0; mode_i = 2'b10; load_i = 16'd9; match_i = 16'd3;
    invert_i = 1'b0; idle(3);
    check(pwm_o == 1'b0, "R10 idle level non-inverted", int'(pwm_o), 0);
    @(negedge clk); enable_i = 1'b1; idle(5);
    pwm_highs(10, h);
    check(h == 6, "R8 duty high cycles", h, 6);
    @(negedge clk); enable_i = 1'b0; invert_i = 1'b1; idle(3);
    check(pwm_o == 1'b1, "R10 idle level inverted", int'(pwm_o), 1);
    @(negedge clk); enable_i = 1'b1; idle(5);
    pwm_highs(10, h);
    check(h == 4, "R9 inverted high cycles", h, 4);
    wait_tout(t1);
    check(pwm_o == 1'b1, "R9 inactive at timeout", int'(pwm_o), 1);
    @(negedge clk); enable_i = 1'b0; invert_i = 1'b0; match_i = 16'd9; idle(2);
    @(negedge clk); enable_i = 1'b1; idle(5);
    pwm_highs(10, h);
    check(h == 0, "R8 match at load gives no high", h, 0);
    @(negedge clk); mode_i = 2'b11; idle(3);
    pwm_highs(15, h);
    check(h == 0 && !tout_o && count_o == 9, "R10 off mode quiet", int'(count_o), 9);

    done = 1'b1;
    summary();
  end

endmodule